// File: doc/BRIEF.md
# Exception Drain and Vectoring Controller

This block decides when a simple in-order-completion core enters an exception handler and where it starts fetching. Three causes are handled: a fetch fault (the fetch hit a no-execute segment or broke a protection rule), a misaligned-operand fault, and a level-sensitive external interrupt. The two faults are synchronous and are taken at once. The interrupt is not. On seeing it, the controller freezes dispatch and waits until the completion buffer is empty, so that any instruction still in flight can raise its own fault first.

The controller owns the interrupt-enable bit of the machine state. Software writes this bit through a small write port, and the controller clears it whenever it takes an exception, so a still-asserted line cannot fire again. A vector-prefix select input chooses between a low and a high handler base. The target address is that base ORed with a per-cause offset.

Top module: `exc_entry_seq`

## Requirements
- R1: A fetch fault (`seg_noexec_i` or `prot_viol_i` high, either or both) sampled while the controller is idle produces `take_o` high in the next cycle, with `take_addr_o` offset 0x400.
- R2: An alignment fault alone gives offset 0x600, and an interrupt gives offset 0x500. When a fetch fault and an alignment fault are sampled together, the fetch fault wins (default ordering).
- R3: `take_addr_o` is the base ORed with the offset. The base is 0x00000000 when `vec_hi_i` is 0 and 0xFFF00000 when it is 1. `vec_hi_i` is sampled in the cycle the take is decided, and the address holds through the take cycle.
- R4: An idle controller with the interrupt enable set that samples `irq_line_i` high and no fault raises `stall_o` in the next cycle. It gives no take until `cbuf_empty_i` is sampled high while draining, and `take_o` rises in the cycle after that sample.
- R5: While the interrupt enable is clear, an asserted `irq_line_i` causes neither stall nor take. Once the enable is written to 1, the line is detected from the following cycle.
- R6: A fault sampled while draining is taken instead of the interrupt (offset 0x400 or 0x600), even if the buffer is empty in the same cycle. The interrupt is not taken afterwards in that episode.
- R7: If `irq_line_i` drops while draining and no fault is present, `stall_o` falls in the next cycle and no take occurs.
- R8: `take_o` lasts exactly one cycle. `stall_o` is high during the take cycle and low in the cycle after it.
- R9: A write through `ee_wr_i` sets `irq_en_o` to `ee_wdata_i` from the next cycle. Taking any exception clears `irq_en_o` at the same edge on which `take_o` rises, and this clear overrides a write in the same cycle.
- R10: After reset, `stall_o`, `take_o`, `irq_en_o` and `take_addr_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| irq_line_i | input | 1 | Level-sensitive external interrupt request |
| cbuf_empty_i | input | 1 | Completion buffer holds no instruction |
| seg_noexec_i | input | 1 | Fetch targeted a no-execute segment |
| prot_viol_i | input | 1 | Fetch violated memory protection |
| align_fault_i | input | 1 | Misaligned-operand fault from an instruction |
| ee_wr_i | input | 1 | Write strobe for the interrupt-enable bit |
| ee_wdata_i | input | 1 | Value written to the interrupt-enable bit |
| vec_hi_i | input | 1 | Vector prefix select (0 low base, 1 high base) |
| stall_o | output | 1 | Dispatch freeze |
| take_o | output | 1 | One-cycle exception take pulse |
| take_addr_o | output | ADDR_W | Handler fetch address for the take |
| irq_en_o | output | 1 | Current interrupt-enable state |

## Verification
The bench builds the block with its default parameters: a 32-bit address, offset field width 12, the low and high bases 0x00000000 and 0xFFF00000, and fetch-before-alignment ordering. With these values every cause, both prefixes and every fault-line combination can be swept exhaustively, and each expected address is computed arithmetically. Drain lengths from zero to four cycles are swept to cover the wait for an empty buffer. The masked, dropped-line and fault-during-drain episodes are each driven on their own.

// File: rtl/exc_pkg.sv
package exc_pkg;
   typedef enum logic [1:0] {
      CAUSE_NONE  = 2'd0,
      CAUSE_FETCH = 2'd1,
      CAUSE_IRQ   = 2'd2,
      CAUSE_ALIGN = 2'd3
   } cause_e;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_DRAIN = 2'd1,
      ST_ISSUE = 2'd2
   } state_e;
endpackage

// File: rtl/exc_prio.sv
// Orders the synchronous fault causes; a parameter picks which one wins.
module exc_prio #(
   parameter bit ALIGN_FIRST = 1'b0
) (
   input  logic              fetch_fault_i,
   input  logic              align_fault_i,
   output logic              hit_o,
   output exc_pkg::cause_e   cause_o
);
   import exc_pkg::*;

   assign hit_o = fetch_fault_i | align_fault_i;

   generate
      if (ALIGN_FIRST) begin : g_align_first
         always_comb begin
            if (align_fault_i)      cause_o = CAUSE_ALIGN;
            else if (fetch_fault_i) cause_o = CAUSE_FETCH;
            else                    cause_o = CAUSE_NONE;
         end
      end else begin : g_fetch_first
         always_comb begin
            if (fetch_fault_i)      cause_o = CAUSE_FETCH;
            else if (align_fault_i) cause_o = CAUSE_ALIGN;
            else                    cause_o = CAUSE_NONE;
         end
      end
   endgenerate
endmodule

// File: rtl/exc_vec_gen.sv
// Forms the handler address from the prefix select and the cause.
module exc_vec_gen #(
   parameter int                ADDR_W    = 32,
   parameter int                OFF_W     = 12,
   parameter logic [ADDR_W-1:0] LO_BASE   = '0,
   parameter logic [ADDR_W-1:0] HI_BASE   = 32'hFFF0_0000,
   parameter int unsigned       OFF_FETCH = 32'h400,
   parameter int unsigned       OFF_IRQ   = 32'h500,
   parameter int unsigned       OFF_ALIGN = 32'h600
) (
   input  logic              vec_hi_i,
   input  exc_pkg::cause_e   cause_i,
   output logic [ADDR_W-1:0] addr_o
);
   import exc_pkg::*;

   localparam logic [OFF_W-1:0] OFS_F = OFF_W'(OFF_FETCH);
   localparam logic [OFF_W-1:0] OFS_I = OFF_W'(OFF_IRQ);
   localparam logic [OFF_W-1:0] OFS_A = OFF_W'(OFF_ALIGN);

   logic [ADDR_W-1:0] base;
   logic [OFF_W-1:0]  ofs;

   assign base = vec_hi_i ? HI_BASE : LO_BASE;

   always_comb begin
      unique case (cause_i)
         CAUSE_FETCH: ofs = OFS_F;
         CAUSE_IRQ:   ofs = OFS_I;
         CAUSE_ALIGN: ofs = OFS_A;
         default:     ofs = '0;
      endcase
   end

   assign addr_o = base | {{(ADDR_W-OFF_W){1'b0}}, ofs};
endmodule

// File: rtl/exc_fsm.sv
// Idle / drain / issue sequencing for exception entry.
module exc_fsm (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              irq_i,
   input  logic              ee_i,
   input  logic              cbuf_empty_i,
   input  logic              sync_hit_i,
   input  exc_pkg::cause_e   sync_cause_i,
   output exc_pkg::state_e   state_o,
   output logic              issue_o,
   output exc_pkg::cause_e   issue_cause_o
);
   import exc_pkg::*;

   state_e st_q, st_d;

   always_comb begin
      st_d          = st_q;
      issue_cause_o = CAUSE_NONE;
      unique case (st_q)
         ST_IDLE: begin
            if (sync_hit_i) begin
               st_d          = ST_ISSUE;
               issue_cause_o = sync_cause_i;
            end else if (irq_i && ee_i) begin
               st_d = ST_DRAIN;
            end
         end
         ST_DRAIN: begin
            if (sync_hit_i) begin
               st_d          = ST_ISSUE;
               issue_cause_o = sync_cause_i;
            end else if (!irq_i || !ee_i) begin
               st_d = ST_IDLE;
            end else if (cbuf_empty_i) begin
               st_d          = ST_ISSUE;
               issue_cause_o = CAUSE_IRQ;
            end
         end
         ST_ISSUE: st_d = ST_IDLE;
         default:  st_d = ST_IDLE;
      endcase
   end

   assign issue_o = (st_d == ST_ISSUE);

   always_ff @(posedge clk_i) begin
      if (!rst_ni) st_q <= ST_IDLE;
      else         st_q <= st_d;
   end

   assign state_o = st_q;
endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq #(
   parameter int                ADDR_W      = 32,
   parameter int                OFF_W       = 12,
   parameter logic [ADDR_W-1:0] LO_BASE     = '0,
   parameter logic [ADDR_W-1:0] HI_BASE     = 32'hFFF0_0000,
   parameter int unsigned       OFF_FETCH   = 32'h400,
   parameter int unsigned       OFF_IRQ     = 32'h500,
   parameter int unsigned       OFF_ALIGN   = 32'h600,
   parameter bit                ALIGN_FIRST = 1'b0
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              irq_line_i,
   input  logic              cbuf_empty_i,
   input  logic              seg_noexec_i,
   input  logic              prot_viol_i,
   input  logic              align_fault_i,
   input  logic              ee_wr_i,
   input  logic              ee_wdata_i,
   input  logic              vec_hi_i,
   output logic              stall_o,
   output logic              take_o,
   output logic [ADDR_W-1:0] take_addr_o,
   output logic              irq_en_o
);
   import exc_pkg::*;

   localparam logic [ADDR_W-1:0] OFF_MASK = ADDR_W'((64'd1 << OFF_W) - 64'd1);

   initial begin
      a_cfg_width: assert (ADDR_W > OFF_W && OFF_W >= 4)
         else $error("address width must exceed offset width");
      a_cfg_base: assert (((LO_BASE & OFF_MASK) == '0) && ((HI_BASE & OFF_MASK) == '0))
         else $error("bases must leave the offset field clear");
      a_cfg_off: assert ((OFF_FETCH >> OFF_W) == 0 && (OFF_IRQ >> OFF_W) == 0 &&
                         (OFF_ALIGN >> OFF_W) == 0)
         else $error("offsets must fit in the offset field");
   end

   logic              fetch_fault;
   logic              sync_hit;
   cause_e            sync_cause;
   cause_e            issue_cause;
   state_e            state;
   logic              issue;
   logic [ADDR_W-1:0] vec_addr;
   logic              ee_q;
   logic [ADDR_W-1:0] addr_q;

   assign fetch_fault = seg_noexec_i | prot_viol_i;

   exc_prio #(.ALIGN_FIRST(ALIGN_FIRST)) u_prio (
      .fetch_fault_i (fetch_fault),
      .align_fault_i (align_fault_i),
      .hit_o         (sync_hit),
      .cause_o       (sync_cause)
   );

   exc_fsm u_fsm (
      .clk_i         (clk_i),
      .rst_ni        (rst_ni),
      .irq_i         (irq_line_i),
      .ee_i          (ee_q),
      .cbuf_empty_i  (cbuf_empty_i),
      .sync_hit_i    (sync_hit),
      .sync_cause_i  (sync_cause),
      .state_o       (state),
      .issue_o       (issue),
      .issue_cause_o (issue_cause)
   );

   exc_vec_gen #(
      .ADDR_W    (ADDR_W),
      .OFF_W     (OFF_W),
      .LO_BASE   (LO_BASE),
      .HI_BASE   (HI_BASE),
      .OFF_FETCH (OFF_FETCH),
      .OFF_IRQ   (OFF_IRQ),
      .OFF_ALIGN (OFF_ALIGN)
   ) u_vec (
      .vec_hi_i (vec_hi_i),
      .cause_i  (issue_cause),
      .addr_o   (vec_addr)
   );

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         ee_q   <= 1'b0;
         addr_q <= '0;
      end else begin
         if (issue)        ee_q <= 1'b0;
         else if (ee_wr_i) ee_q <= ee_wdata_i;
         if (issue)        addr_q <= vec_addr;
      end
   end

   assign stall_o     = (state != ST_IDLE);
   assign take_o      = (state == ST_ISSUE);
   assign take_addr_o = addr_q;
   assign irq_en_o    = ee_q;
endmodule

// File: rtl/exc_entry_seq_chk.sv
module exc_entry_seq_chk #(
   parameter int          ADDR_W    = 32,
   parameter int unsigned OFF_FETCH = 32'h400,
   parameter int unsigned OFF_IRQ   = 32'h500
) (
   input logic              clk_i,
   input logic              rst_ni,
   input logic              irq_line_i,
   input logic              cbuf_empty_i,
   input logic              seg_noexec_i,
   input logic              prot_viol_i,
   input logic              align_fault_i,
   input logic              stall_o,
   input logic              take_o,
   input logic [ADDR_W-1:0] take_addr_o,
   input logic              irq_en_o
);
   localparam logic [11:0] LOW_F = OFF_FETCH[11:0];
   localparam logic [11:0] LOW_I = OFF_IRQ[11:0];

   logic any_fault;
   assign any_fault = seg_noexec_i | prot_viol_i | align_fault_i;

   p_fetch_take_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!stall_o && (seg_noexec_i || prot_viol_i)) |=> (take_o && take_addr_o[11:0] == LOW_F));

   p_irq_stall_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!stall_o && irq_line_i && irq_en_o && !any_fault) |=> (stall_o && !take_o));

   p_irq_waits_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (take_o && take_addr_o[11:0] == LOW_I) |-> $past(cbuf_empty_i));

   p_masked_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!stall_o && !irq_en_o && !any_fault) |=> !stall_o);

   p_drop_idle_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (stall_o && !take_o && !irq_line_i && !any_fault) |=> (!stall_o && !take_o));

   p_take_single_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      take_o |=> !take_o);

   p_stall_span_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      take_o |-> stall_o);

   p_stall_release_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      take_o |=> !stall_o);

   p_ee_cleared_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      take_o |-> !irq_en_o);
endmodule

bind exc_entry_seq exc_entry_seq_chk #(
   .ADDR_W    (ADDR_W),
   .OFF_FETCH (OFF_FETCH),
   .OFF_IRQ   (OFF_IRQ)
) u_chk (
   .clk_i         (clk_i),
   .rst_ni        (rst_ni),
   .irq_line_i    (irq_line_i),
   .cbuf_empty_i  (cbuf_empty_i),
   .seg_noexec_i  (seg_noexec_i),
   .prot_viol_i   (prot_viol_i),
   .align_fault_i (align_fault_i),
   .stall_o       (stall_o),
   .take_o        (take_o),
   .take_addr_o   (take_addr_o),
   .irq_en_o      (irq_en_o)
);

// File: tb/exc_entry_seq_tb_top.sv
`timescale 1ns/1ps
module exc_entry_seq_tb_top;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        irq_line, cbuf_empty, seg_noexec, prot_viol, align_fault;
   logic        ee_wr, ee_wdata, vec_hi;
   logic        stall, take, irq_en;
   logic [31:0] take_addr;

   int n_cmp = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #10 clk = ~clk;

   exc_entry_seq dut_i (
      .clk_i         (clk),
      .rst_ni        (rst_n),
      .irq_line_i    (irq_line),
      .cbuf_empty_i  (cbuf_empty),
      .seg_noexec_i  (seg_noexec),
      .prot_viol_i   (prot_viol),
      .align_fault_i (align_fault),
      .ee_wr_i       (ee_wr),
      .ee_wdata_i    (ee_wdata),
      .vec_hi_i      (vec_hi),
      .stall_o       (stall),
      .take_o        (take),
      .take_addr_o   (take_addr),
      .irq_en_o      (irq_en)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   function automatic logic [31:0] vaddr(input logic ip, input logic [31:0] off);
      return (ip ? 32'hFFF0_0000 : 32'h0) | off;
   endfunction

   task automatic set_ee(input logic v);
      ee_wr = 1'b1; ee_wdata = v;
      step();
      ee_wr = 1'b0;
      chk("R9 enable write", {31'd0, irq_en}, {31'd0, v});
   endtask

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: actual running expected finished");
         summary();
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0; irq_line = 0; cbuf_empty = 0; seg_noexec = 0; prot_viol = 0;
      align_fault = 0; ee_wr = 0; ee_wdata = 0; vec_hi = 0;
      @(negedge clk);
      step(); step();
      // R10 reset state
      chk("R10 stall", {31'd0, stall}, 32'd0);
      chk("R10 take", {31'd0, take}, 32'd0);
      chk("R10 enable", {31'd0, irq_en}, 32'd0);
      chk("R10 addr", take_addr, 32'd0);
      rst_n = 1'b1;
      step();

      // R1 R2 R3: every fault-line combination under both prefixes
      for (int ip = 0; ip < 2; ip++) begin
         for (int code = 1; code < 8; code++) begin
            logic [31:0] off;
            set_ee(1'b1);
            off = (code[0] || code[1]) ? 32'h400 : 32'h600;
            vec_hi = ip[0];
            seg_noexec = code[0]; prot_viol = code[1]; align_fault = code[2];
            step();
            seg_noexec = 0; prot_viol = 0; align_fault = 0;
            vec_hi = ~ip[0];
            #1;
            chk(off == 32'h400 ? "R1 fetch take" : "R2 align take", {31'd0, take}, 32'd1);
            chk("R3 address", take_addr, vaddr(ip[0], off));
            chk("R8 stall in take", {31'd0, stall}, 32'd1);
            chk("R9 cleared on take", {31'd0, irq_en}, 32'd0);
            step();
            chk("R8 take single", {31'd0, take}, 32'd0);
            chk("R8 stall release", {31'd0, stall}, 32'd0);
         end
      end

      // R4: interrupt with drain lengths 0..4
      for (int ip = 0; ip < 2; ip++) begin
         for (int len = 0; len < 5; len++) begin
            set_ee(1'b1);
            vec_hi = ip[0]; irq_line = 1; cbuf_empty = 0;
            step();
            chk("R4 stall on detect", {31'd0, stall}, 32'd1);
            chk("R4 no early take", {31'd0, take}, 32'd0);
            for (int k = 0; k < len; k++) begin
               step();
               chk("R4 waiting stall", {31'd0, stall}, 32'd1);
               chk("R4 waiting no take", {31'd0, take}, 32'd0);
            end
            cbuf_empty = 1;
            step();
            cbuf_empty = 0;
            chk("R4 irq take", {31'd0, take}, 32'd1);
            chk("R3 irq address", take_addr, vaddr(ip[0], 32'h500));
            chk("R9 cleared on irq take", {31'd0, irq_en}, 32'd0);
            step();
            chk("R8 take single", {31'd0, take}, 32'd0);
            chk("R8 stall release", {31'd0, stall}, 32'd0);
            step();
            chk("R9 no retrigger", {31'd0, stall}, 32'd0);
            irq_line = 0;
         end
      end

      // R5: masked interrupt stays pending
      irq_line = 1;
      for (int k = 0; k < 4; k++) begin
         step();
         chk("R5 masked no stall", {31'd0, stall}, 32'd0);
         chk("R5 masked no take", {31'd0, take}, 32'd0);
      end
      ee_wr = 1; ee_wdata = 1;
      step();
      ee_wr = 0;
      chk("R5 enable write cycle", {31'd0, stall}, 32'd0);
      step();
      chk("R5 detected after enable", {31'd0, stall}, 32'd1);

      // R7: line drops while draining
      step();
      chk("R7 still draining", {31'd0, stall}, 32'd1);
      irq_line = 0;
      step();
      chk("R7 stall drops", {31'd0, stall}, 32'd0);
      chk("R7 no take", {31'd0, take}, 32'd0);
      chk("R7 enable kept", {31'd0, irq_en}, 32'd1);

      // R6: fault while draining wins over the interrupt
      for (int kind = 0; kind < 2; kind++) begin
         set_ee(1'b1);
         vec_hi = 1; irq_line = 1; cbuf_empty = 0;
         step();
         step();
         chk("R6 draining", {31'd0, stall}, 32'd1);
         if (kind == 0) seg_noexec = 1; else align_fault = 1;
         cbuf_empty = 1;
         step();
         seg_noexec = 0; align_fault = 0; cbuf_empty = 0;
         chk("R6 fault take", {31'd0, take}, 32'd1);
         chk("R6 fault address", take_addr, vaddr(1'b1, kind == 0 ? 32'h400 : 32'h600));
         step();
         chk("R6 no irq after", {31'd0, take}, 32'd0);
         step();
         chk("R6 no irq stall", {31'd0, stall}, 32'd0);
         irq_line = 0;
      end

      // R9: take clear overrides a same-cycle write
      set_ee(1'b1);
      prot_viol = 1; ee_wr = 1; ee_wdata = 1;
      step();
      prot_viol = 0; ee_wr = 0;
      chk("R9 take beats write", {31'd0, irq_en}, 32'd0);
      chk("R1 protection take", {31'd0, take}, 32'd1);
      step();

      done = 1'b1;
      summary();
      $finish;
   end
endmodule